// File: doc/BRIEF.md
# Hardware Return-Address Stack

This block keeps the return addresses of a small microcontroller core in hardware. When the core executes a subroutine call, the block stores the current program counter. When the core takes an interrupt, the block does the same. A return or return-from-interrupt takes the most recent address back off the stack. The storage and its level pointer have no software access path. The only way to reach them is through the call, return and interrupt strobes.

The block also decides when an interrupt may be acknowledged. A request that arrives while all levels are occupied is remembered but not taken. It is acknowledged in the first cycle that has a free level and no call or return. A call made into a full stack still succeeds: it overwrites the oldest entry, so the newest eight addresses remain. A return from an empty stack changes nothing. The returned address keeps the value of the last successful pop, and the depth stays at zero.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset, `full_o` is 0, `ret_pc_o` is 0, `irq_ack_o` is 0 while no request is present, and the stack holds no entries.
- R2: A cycle with `call_i`=1 stores `pc_i`. A later cycle with `ret_i`=1 delivers the most recently stored, not yet returned address on `ret_pc_o`, starting in the cycle after the return strobe. The order is last-in first-out. `call_i` and `ret_i` are never high in the same cycle.
- R3: The stack holds 8 addresses. `full_o` rises after the eighth unreturned push and falls one cycle after a return from a full stack.
- R4: A call made while `full_o`=1 discards the oldest entry and keeps `full_o` high. The following 8 returns deliver the 8 most recent addresses, newest first.
- R5: A return while the stack is empty leaves `ret_pc_o` unchanged and the depth at zero. After it, exactly 8 calls are needed to raise `full_o`.
- R6: When the stack is not full and neither `call_i` nor `ret_i` is high, an interrupt request is acknowledged combinationally in the same cycle (`irq_ack_o`=1). That cycle's `pc_i` is pushed.
- R7: A request seen while `full_o`=1 is held without acknowledgement for as long as the stack stays full. It is acknowledged in the first cycle after a return that has no call or return, and that cycle's `pc_i` is pushed.
- R8: A request that coincides with `call_i` or `ret_i` is not acknowledged in that cycle. It is acknowledged once, in the next eligible cycle, even if the request line has dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Subroutine call: push `pc_i` |
| ret_i | input | 1 | Return of either kind: pop the newest entry |
| irq_req_i | input | 1 | Unmasked interrupt request, latched inside |
| pc_i | input | PCW (13) | Current program counter, the address to store |
| ret_pc_o | output | PCW (13) | Address taken by the last successful pop |
| irq_ack_o | output | 1 | Interrupt acknowledge; the cycle's `pc_i` is pushed |
| full_o | output | 1 | All levels occupied |

## Verification
The hardest state to reach is an interrupt that has been held back by a full stack and is then released by a return. The stimulus fills the stack with calls and raises the request once, then keeps the request line low for several idle cycles. Next it issues a single return and checks that the acknowledge appears in the next idle cycle, not the return cycle. Popping afterwards must deliver the program counter of the acknowledge cycle ahead of the calls beneath it. A second sequence places a request on the same cycle as a call and as a return, to confirm the deferral and that the acknowledge is given only once.

// File: rtl/ras_pkg.sv
package ras_pkg;

  // Circular index step forward, wrapping at n
  function automatic int unsigned ring_next(int unsigned p, int unsigned n);
    return (p == n - 1) ? 0 : p + 1;
  endfunction

  // Circular index step backward, wrapping at n
  function automatic int unsigned ring_prev(int unsigned p, int unsigned n);
    return (p == 0) ? n - 1 : p - 1;
  endfunction

  // Occupancy after a push: saturates at capacity (oldest dropped)
  function automatic int unsigned level_after_push(int unsigned lvl, int unsigned cap);
    return (lvl >= cap) ? cap : lvl + 1;
  endfunction

endpackage

// File: rtl/ras_slots.sv
module ras_slots #(
  parameter int unsigned PCW   = 13,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PTRW  = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [PTRW-1:0] wr_idx,
  input  logic [PCW-1:0]  wr_data,
  input  logic [PTRW-1:0] rd_idx,
  output logic [PCW-1:0]  rd_data
);

  logic [PCW-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (wr_en && (wr_idx == PTRW'(g))) begin
        slot_q[g] <= wr_data;
      end
    end
  end

  assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/ras_level_ctrl.sv
module ras_level_ctrl #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PTRW  = $clog2(DEPTH),
  parameter int unsigned CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  output logic [PTRW-1:0] wr_idx,
  output logic [PTRW-1:0] top_idx,
  output logic [CNTW-1:0] level,
  output logic            full,
  output logic            pop_ok,
  output logic            pop_empty
);

  logic [PTRW-1:0] wptr_q;
  logic [CNTW-1:0] level_q;
  logic            empty;

  assign empty     = (level_q == '0);
  assign full      = (level_q == CNTW'(DEPTH));
  assign pop_ok    = pop && !push && !empty;
  assign pop_empty = pop && !push && empty;
  assign wr_idx    = wptr_q;
  assign top_idx   = PTRW'(ras_pkg::ring_prev(32'(wptr_q), DEPTH));
  assign level     = level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      level_q <= '0;
    end else if (push) begin
      wptr_q  <= PTRW'(ras_pkg::ring_next(32'(wptr_q), DEPTH));
      level_q <= CNTW'(ras_pkg::level_after_push(32'(level_q), DEPTH));
    end else if (pop_ok) begin
      wptr_q  <= top_idx;
      level_q <= level_q - 1'b1;
    end
  end

endmodule

// File: rtl/ras_irq_gate.sv
module ras_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_req,
  input  logic full,
  input  logic busy,
  output logic ack,
  output logic pending
);

  logic pend_q;
  logic want;

  assign want    = pend_q || irq_req;
  assign ack     = want && !full && !busy;
  assign pending = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= want && !ack;
    end
  end

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
  parameter int unsigned PCW   = 13,
  parameter int unsigned DEPTH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           call_i,
  input  logic           ret_i,
  input  logic           irq_req_i,
  input  logic [PCW-1:0] pc_i,
  output logic [PCW-1:0] ret_pc_o,
  output logic           irq_ack_o,
  output logic           full_o
);

  localparam int unsigned PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNTW = $clog2(DEPTH + 1);

  // Named internal events
  logic            push_evt;
  logic            pop_evt;
  logic            pop_empty_evt;
  logic            ack_w;
  logic            full_w;
  logic            pend_w;
  logic [CNTW-1:0] depth_w;
  logic [PTRW-1:0] wr_idx_w;
  logic [PTRW-1:0] top_idx_w;
  logic [PCW-1:0]  top_data_w;
  logic [PCW-1:0]  ret_pc_q;

  assign push_evt = call_i || ack_w;

  ras_irq_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_req (irq_req_i),
    .full    (full_w),
    .busy    (call_i || ret_i),
    .ack     (ack_w),
    .pending (pend_w)
  );

  ras_level_ctrl #(.DEPTH(DEPTH), .PTRW(PTRW), .CNTW(CNTW)) u_level (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_evt),
    .pop       (ret_i),
    .wr_idx    (wr_idx_w),
    .top_idx   (top_idx_w),
    .level     (depth_w),
    .full      (full_w),
    .pop_ok    (pop_evt),
    .pop_empty (pop_empty_evt)
  );

  ras_slots #(.PCW(PCW), .DEPTH(DEPTH), .PTRW(PTRW)) u_slots (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (push_evt),
    .wr_idx  (wr_idx_w),
    .wr_data (pc_i),
    .rd_idx  (top_idx_w),
    .rd_data (top_data_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_pc_q <= '0;
    end else if (pop_evt) begin
      ret_pc_q <= top_data_w;
    end
  end

  assign ret_pc_o  = ret_pc_q;
  assign irq_ack_o = ack_w;
  assign full_o    = full_w;

endmodule

// File: rtl/ret_addr_stack_chk.sv
module ret_addr_stack_chk #(
  parameter int unsigned PCW   = 13,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNTW  = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            call_i,
  input logic            ret_i,
  input logic            irq_req_i,
  input logic            irq_ack_o,
  input logic            full_o,
  input logic [PCW-1:0]  ret_pc_o,
  input logic [CNTW-1:0] depth,
  input logic            pend,
  input logic            pop_empty
);

  assert_call_ret_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(call_i && ret_i));

  assert_depth_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CNTW'(DEPTH));

  assert_full_released_by_ret_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && ret_i && !call_i) |=> !full_o);

  assert_call_keeps_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && call_i) |=> full_o);

  assert_empty_pop_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_empty |=> ($stable(ret_pc_o) && depth == '0));

  assert_ack_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_o |-> (irq_req_i || pend));

  assert_no_ack_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !irq_ack_o);

  assert_held_irq_served_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !full_o && !call_i && !ret_i) |-> irq_ack_o);

  assert_ack_avoids_call_ret_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_o |-> (!call_i && !ret_i));

  assert_single_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack_o && !irq_req_i) |=> !pend);

endmodule

bind ret_addr_stack ret_addr_stack_chk #(.PCW(PCW), .DEPTH(DEPTH), .CNTW(CNTW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .call_i    (call_i),
  .ret_i     (ret_i),
  .irq_req_i (irq_req_i),
  .irq_ack_o (irq_ack_o),
  .full_o    (full_o),
  .ret_pc_o  (ret_pc_o),
  .depth     (depth_w),
  .pend      (pend_w),
  .pop_empty (pop_empty_evt)
);

// File: tb/ret_addr_stack_bench.sv
module ret_addr_stack_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PCW   = 13;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic call_i = 1'b0, ret_i = 1'b0, irq_req_i = 1'b0;
  logic [PCW-1:0] pc_i = '0;
  logic [PCW-1:0] ret_pc_o;
  logic irq_ack_o, full_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  string cur_req = "R1";

  logic [PCW-1:0] model[$];
  logic [PCW-1:0] exp_q[$];
  logic [PCW-1:0] last_pop = '0;
  bit model_pend = 1'b0;

  ret_addr_stack #(.PCW(PCW), .DEPTH(DEPTH)) u_ret_addr_stack (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
    .irq_req_i(irq_req_i), .pc_i(pc_i), .ret_pc_o(ret_pc_o),
    .irq_ack_o(irq_ack_o), .full_o(full_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Driver: one cycle of stimulus, model update, scoreboard push
  task automatic step(bit c, bit r, bit q, logic [PCW-1:0] pc);
    bit exp_ack;
    @(negedge clk);
    check(cur_req, "full_o", 32'(full_o), 32'(model.size() == DEPTH));
    call_i = c; ret_i = r; irq_req_i = q; pc_i = pc;
    #1;
    exp_ack = (model_pend || q) && (model.size() < DEPTH) && !c && !r;
    check(cur_req, "irq_ack_o", 32'(irq_ack_o), 32'(exp_ack));
    model_pend = (model_pend || q) && !exp_ack;
    if (c || exp_ack) begin
      if (model.size() == DEPTH) void'(model.pop_front());
      model.push_back(pc);
    end else if (r) begin
      if (model.size() > 0) last_pop = model.pop_back();
      exp_q.push_back(last_pop);
    end
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic drain();
    while (model.size() > 0) step(1'b0, 1'b1, 1'b0, '0);
    idle();
  endtask

  // Monitor: compare popped address the cycle after a return
  initial begin
    forever begin
      bit r;
      @(posedge clk);
      r = ret_i && !call_i;
      #1;
      if (r) begin
        if (exp_q.size() == 0) begin
          check(cur_req, "scoreboard empty", 32'd0, 32'd1);
        end else begin
          check(cur_req, "ret_pc_o", 32'(ret_pc_o), 32'(exp_q.pop_front()));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1", "full_o", 32'(full_o), 32'd0);
    check("R1", "ret_pc_o", 32'(ret_pc_o), 32'd0);
    check("R1", "irq_ack_o", 32'(irq_ack_o), 32'd0);

    // R5 return on an empty stack right after reset
    cur_req = "R5";
    step(1'b0, 1'b1, 1'b0, '0);
    idle();

    // R2 LIFO order, mixed pattern
    cur_req = "R2";
    step(1'b1, 1'b0, 1'b0, 13'h0A1);
    step(1'b1, 1'b0, 1'b0, 13'h1B2);
    step(1'b1, 1'b0, 1'b0, 13'h1FFF);
    step(1'b0, 1'b1, 1'b0, '0);
    step(1'b1, 1'b0, 1'b0, 13'h0003);
    step(1'b0, 1'b1, 1'b0, '0);
    step(1'b0, 1'b1, 1'b0, '0);
    step(1'b0, 1'b1, 1'b0, '0);
    idle();

    // R3 capacity and full flag
    cur_req = "R3";
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, 1'b0, PCW'(13'h200 + i));
    idle();
    step(1'b0, 1'b1, 1'b0, '0);
    step(1'b1, 1'b0, 1'b0, 13'h0ABC);
    idle();

    // R4 calls into a full stack drop the oldest
    cur_req = "R4";
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, PCW'(13'h300 + i));
    drain();

    // R5 extra return on empty, then exactly 8 calls to fill
    cur_req = "R5";
    step(1'b0, 1'b1, 1'b0, '0);
    step(1'b0, 1'b1, 1'b0, '0);
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, 1'b0, PCW'(13'h400 + i));
    idle();
    drain();

    // R6 immediate acknowledge
    cur_req = "R6";
    step(1'b1, 1'b0, 1'b0, 13'h0500);
    step(1'b0, 1'b0, 1'b1, 13'h0601);
    idle();
    drain();

    // R7 held while full, served after a return
    cur_req = "R7";
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, 1'b0, PCW'(13'h700 + i));
    step(1'b0, 1'b0, 1'b1, 13'h0777);
    idle(); idle(); idle();
    step(1'b0, 1'b1, 1'b0, '0);
    step(1'b0, 1'b0, 1'b0, 13'h0555);
    idle();
    drain();

    // R8 request coinciding with call and with return
    cur_req = "R8";
    step(1'b1, 1'b0, 1'b1, 13'h0801);
    step(1'b0, 1'b0, 1'b0, 13'h0802);
    idle();
    step(1'b0, 1'b1, 1'b1, '0);
    step(1'b0, 1'b0, 1'b0, 13'h0803);
    idle();
    drain();
    idle();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule